// File: doc/BRIEF.md
# Alert Class Escalation Controller

This block runs the escalation side of one alert class. It counts classified alert hits in a saturating accumulator. It tracks how long the class interrupt has stayed pending. When the class has to escalate, it steps through four programmable phases and then parks in a terminal state. A single counter times both the interrupt timeout and the phase lengths, because the two never run at the same time.

Each of the four escalation request lines can be enabled on its own and mapped to any of the four phases. Software can clear the accumulator and abort an escalation with a clear strobe, but only while clear is permitted. When the lock bit is set, that permission is withdrawn for good as soon as escalation starts. The interrupt register itself and the differential signalling of the escalation lines sit outside this block.

Top module: `esc_class_ctrl`

## Requirements
- R1: The accumulator is 16 bits wide and saturates at 0xFFFF. It rises by exactly one in each cycle in which any bit of `alert_hit_i` is high, however many bits are high.
- R2: A hit that arrives while the class is enabled, the controller is in Idle or Timeout, and the accumulator equals `acc_thresh_i` starts escalation, and `state_o` shows Phase0 on the next clock. A threshold of 0 escalates on the first hit, and a threshold of N escalates on hit N+1.
- R3: `state_o` uses this encoding: Idle=0, Timeout=1, Phase0=2, Phase1=3, Phase2=4, Phase3=5, Terminal=6. After reset the state is Idle, the accumulator and counter are 0, and all escalation lines are low.
- R4: In Idle, with the class enabled, `irq_pend_i` high and `tmo_cyc_i` nonzero, the controller enters Timeout with the counter at 1. The counter then rises by one per cycle. Timeout lasts `tmo_cyc_i` cycles before Phase0. A `tmo_cyc_i` of 0 never leaves Idle.
- R5: If `irq_pend_i` drops while in Timeout, the controller returns to Idle with the counter at 0 on the next clock.
- R6: Phase k lasts `phase_cyc_i[32k+31:32k]`+1 cycles, and the counter restarts at 0 in each phase. After Phase3 the controller enters Terminal with the counter at 0. An accumulation trigger during Timeout moves straight to Phase0.
- R7: `esc_o[i]` is high exactly while `out_en_i[i]` is high and the state is the phase selected by `out_map_i[2i+1:2i]`. The field value 0..3 selects Phase0..Phase3.
- R8: Terminal is held until a permitted clear or a reset, and new hits do not change it.
- R9: A clear strobe with `clr_en_i` high (and clear not locked out) sets the accumulator to 0, the state to Idle and the counter to 0 on the next clock. A clear with `clr_en_i` low has no effect.
- R10: If `lock_i` is high when escalation starts, every later clear strobe is ignored until reset.
- R11: With `cls_en_i` low, neither accumulation nor a pending interrupt moves the controller out of Idle. The accumulator still counts hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| alert_hit_i | input | N_SRC | Classified alert triggers of this class |
| irq_pend_i | input | 1 | Class interrupt pending |
| clr_i | input | 1 | Software clear strobe |
| cls_en_i | input | 1 | Class enable |
| lock_i | input | 1 | Withdraw clear permission when escalation starts |
| clr_en_i | input | 1 | Software clear permission |
| acc_thresh_i | input | ACC_W | Accumulation threshold |
| tmo_cyc_i | input | CNT_W | Interrupt timeout in cycles, 0 disables |
| phase_cyc_i | input | 4*CNT_W | Phase lengths, phase k in slice k |
| out_en_i | input | N_OUT | Per-line escalation enables |
| out_map_i | input | 2*N_OUT | Per-line phase selection |
| esc_o | output | N_OUT | Escalation request lines |
| state_o | output | 3 | Controller state |
| acc_o | output | ACC_W | Accumulator value |
| cnt_o | output | CNT_W | Shared timeout/phase counter |

## Verification
The hardest situation to reach from the ports is accumulator saturation. It needs 65,535 counted hits. The bench gets there by disabling the class, so that no escalation gets in the way, and holding a hit high for slightly more than that many cycles. The permanent lockout is also awkward to reach, because it cannot be undone without reset. For that reason it runs last: the bench triggers escalation with the lock set, then strobes clear and shows that both the state and the accumulator are left alone.

// File: rtl/esc_class_pkg.sv
// Shared definitions for the alert class escalation controller.
package esc_class_pkg;
    localparam int N_PH  = 4;              // number of escalation phases
    localparam int MAP_W = $clog2(N_PH);   // width of a phase selector

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_TMO  = 3'd1,
        ST_PH0  = 3'd2,
        ST_PH1  = 3'd3,
        ST_PH2  = 3'd4,
        ST_PH3  = 3'd5,
        ST_TERM = 3'd6
    } esc_state_e;
endpackage

// File: rtl/esc_accum.sv
// Saturating alert accumulator.
// ORs all hit sources into one increment per cycle. A clear wins over an
// increment. Flags a hit that lands while the count equals the threshold.
// Assumes the clear input is already qualified by the permission logic.
module esc_accum #(
    parameter int ACC_W = 16,
    parameter int N_SRC = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_SRC-1:0] hit_i,
    input  logic             clr_i,
    input  logic [ACC_W-1:0] thresh_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             thr_hit_o
);
    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

    logic             any_hit;
    logic [ACC_W-1:0] acc_q;

    // Reduce all sources to a single increment request.
    always_comb any_hit = |hit_i;

    // Count hits, holding at the maximum value.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            acc_q <= '0;
        else if (clr_i)
            acc_q <= '0;
        else if (any_hit && acc_q != ACC_MAX)
            acc_q <= acc_q + 1'b1;
    end

    // Flag a hit that arrives with the count at the threshold.
    always_comb thr_hit_o = any_hit && (acc_q == thresh_i);

    assign acc_o = acc_q;
endmodule

// File: rtl/esc_phase_fsm.sv
// Timeout and phase sequencer.
// Moves from Idle to Timeout, then through four phases to Terminal. One
// counter times the timeout and every phase. The accumulation trigger must
// already be gated by the class enable. The clear must already be qualified.
module esc_phase_fsm
    import esc_class_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  en_i,
    input  logic                  clr_i,
    input  logic                  acc_trig_i,
    input  logic                  irq_pend_i,
    input  logic [CNT_W-1:0]      tmo_cyc_i,
    input  logic [N_PH*CNT_W-1:0] phase_cyc_i,
    output esc_state_e            state_o,
    output logic [CNT_W-1:0]      cnt_o,
    output logic                  start_o
);
    esc_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] len_arr [N_PH];
    logic [CNT_W-1:0] cur_len;
    logic [2:0]       ph_off;
    logic [MAP_W-1:0] ph_idx;

    // Unpack the flattened phase-length bus.
    for (genvar k = 0; k < N_PH; k++) begin : g_len
        assign len_arr[k] = phase_cyc_i[k*CNT_W +: CNT_W];
    end

    // Select the length of the phase currently running.
    always_comb begin
        ph_off  = 3'(st_q) - 3'(ST_PH0);
        ph_idx  = ph_off[MAP_W-1:0];
        cur_len = len_arr[ph_idx];
    end

    // Compute the next state, the next count and the escalation start pulse.
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        start_o = 1'b0;
        if (clr_i) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (acc_trig_i) begin
                        st_d    = ST_PH0;
                        cnt_d   = '0;
                        start_o = 1'b1;
                    end else if (en_i && irq_pend_i && tmo_cyc_i != '0) begin
                        st_d  = ST_TMO;
                        cnt_d = CNT_W'(1);
                    end
                end
                ST_TMO: begin
                    if (acc_trig_i) begin
                        st_d    = ST_PH0;
                        cnt_d   = '0;
                        start_o = 1'b1;
                    end else if (!en_i || !irq_pend_i) begin
                        st_d  = ST_IDLE;
                        cnt_d = '0;
                    end else if (cnt_q >= tmo_cyc_i) begin
                        st_d    = ST_PH0;
                        cnt_d   = '0;
                        start_o = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_PH0, ST_PH1, ST_PH2, ST_PH3: begin
                    if (cnt_q >= cur_len) begin
                        st_d  = (st_q == ST_PH3) ? ST_TERM : esc_state_e'(3'(st_q) + 3'd1);
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_TERM: begin
                    cnt_d = '0;
                end
                default: begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // Register the state and the shared counter.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state_o = st_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/esc_out_map.sv
// Escalation line mapper.
// Drives each line while its enable is set and the state is its mapped phase.
// Purely combinational from the registered state, so the lines are glitch-free
// relative to the state register.
module esc_out_map
    import esc_class_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input  esc_state_e             state_i,
    input  logic [N_OUT-1:0]       en_i,
    input  logic [MAP_W*N_OUT-1:0] map_i,
    output logic [N_OUT-1:0]       esc_o
);
    logic             in_phase;
    logic [2:0]       ph_off;
    logic [MAP_W-1:0] ph_idx;

    // Decode whether a phase is active, and which one.
    always_comb begin
        in_phase = (state_i == ST_PH0) || (state_i == ST_PH1) ||
                   (state_i == ST_PH2) || (state_i == ST_PH3);
        ph_off   = 3'(state_i) - 3'(ST_PH0);
        ph_idx   = ph_off[MAP_W-1:0];
    end

    // Compare each line's mapping with the active phase.
    for (genvar i = 0; i < N_OUT; i++) begin : g_line
        assign esc_o[i] = en_i[i] && in_phase && (map_i[i*MAP_W +: MAP_W] == ph_idx);
    end
endmodule

// File: rtl/esc_class_ctrl.sv
// Alert class escalation controller (top).
// Ties together the accumulator, the sequencer and the line mapper. Holds
// the sticky clear lockout. Assumes all configuration is quasi-static.
module esc_class_ctrl
    import esc_class_pkg::*;
#(
    parameter int ACC_W = 16,
    parameter int CNT_W = 32,
    parameter int N_SRC = 3,
    parameter int N_OUT = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [N_SRC-1:0]       alert_hit_i,
    input  logic                   irq_pend_i,
    input  logic                   clr_i,
    input  logic                   cls_en_i,
    input  logic                   lock_i,
    input  logic                   clr_en_i,
    input  logic [ACC_W-1:0]       acc_thresh_i,
    input  logic [CNT_W-1:0]       tmo_cyc_i,
    input  logic [N_PH*CNT_W-1:0]  phase_cyc_i,
    input  logic [N_OUT-1:0]       out_en_i,
    input  logic [MAP_W*N_OUT-1:0] out_map_i,
    output logic [N_OUT-1:0]       esc_o,
    output logic [2:0]             state_o,
    output logic [ACC_W-1:0]       acc_o,
    output logic [CNT_W-1:0]       cnt_o
);
    logic       clr_ok_q;
    logic       clr_eff;
    logic       thr_hit;
    logic       acc_trig;
    logic       esc_start;
    esc_state_e st;

    // Qualify the software clear with its enable and the lockout.
    always_comb clr_eff = clr_i && clr_en_i && clr_ok_q;

    // Only an enabled class may escalate through accumulation.
    always_comb acc_trig = thr_hit && cls_en_i;

    // Withdraw clear permission once escalation starts while locked.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            clr_ok_q <= 1'b1;
        else if (lock_i && esc_start)
            clr_ok_q <= 1'b0;
    end

    esc_accum #(.ACC_W(ACC_W), .N_SRC(N_SRC)) u_accum (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hit_i     (alert_hit_i),
        .clr_i     (clr_eff),
        .thresh_i  (acc_thresh_i),
        .acc_o     (acc_o),
        .thr_hit_o (thr_hit)
    );

    esc_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (cls_en_i),
        .clr_i       (clr_eff),
        .acc_trig_i  (acc_trig),
        .irq_pend_i  (irq_pend_i),
        .tmo_cyc_i   (tmo_cyc_i),
        .phase_cyc_i (phase_cyc_i),
        .state_o     (st),
        .cnt_o       (cnt_o),
        .start_o     (esc_start)
    );

    esc_out_map #(.N_OUT(N_OUT)) u_map (
        .state_i (st),
        .en_i    (out_en_i),
        .map_i   (out_map_i),
        .esc_o   (esc_o)
    );

    assign state_o = 3'(st);
endmodule

// File: rtl/esc_class_ctrl_chk.sv
// Property checker for the escalation controller; bound to the top module.
module esc_class_ctrl_chk #(
    parameter int ACC_W = 16,
    parameter int CNT_W = 32,
    parameter int N_OUT = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cls_en_i,
    input logic             clr_i,
    input logic [N_OUT-1:0] esc_o,
    input logic [2:0]       state_o,
    input logic [ACC_W-1:0] acc_o,
    input logic [CNT_W-1:0] cnt_o
);
    localparam logic [ACC_W-1:0] ACC_TOP = {ACC_W{1'b1}};

    AST_ACC_HOLD_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_o == ACC_TOP) |=> (acc_o == ACC_TOP || acc_o == '0)); // R1

    AST_ACC_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (acc_o == $past(acc_o) || acc_o == ACC_W'($past(acc_o) + 1'b1) || acc_o == '0)); // R1

    AST_PH0_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd2 && $past(state_o) != 3'd2) |-> ($past(state_o) <= 3'd1)); // R2

    AST_TERM_ZERO_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd6) |-> (cnt_o == '0)); // R6

    AST_LINES_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o < 3'd2 || state_o > 3'd5) |-> (esc_o == '0)); // R7

    AST_TERM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd6 && !clr_i) |=> (state_o == 3'd6)); // R8

    AST_DISABLED_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd0 && !cls_en_i) |=> (state_o == 3'd0)); // R11
endmodule

bind esc_class_ctrl esc_class_ctrl_chk #(
    .ACC_W(ACC_W), .CNT_W(CNT_W), .N_OUT(N_OUT)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cls_en_i (cls_en_i),
    .clr_i    (clr_i),
    .esc_o    (esc_o),
    .state_o  (state_o),
    .acc_o    (acc_o),
    .cnt_o    (cnt_o)
);

// File: tb/esc_class_ctrl_tb.sv
// Directed bench for the escalation controller.
module esc_class_ctrl_tb;
    localparam int ACC_W = 16;
    localparam int CNT_W = 32;
    localparam int N_SRC = 3;
    localparam int N_OUT = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N_SRC-1:0]     hit = '0;
    logic                 pend = 1'b0;
    logic                 clr = 1'b0;
    logic                 en = 1'b1;
    logic                 lock = 1'b0;
    logic                 clr_en = 1'b0;
    logic [ACC_W-1:0]     thresh = '0;
    logic [CNT_W-1:0]     tmo = '0;
    logic [4*CNT_W-1:0]   ph = '0;
    logic [N_OUT-1:0]     oen = '1;
    logic [2*N_OUT-1:0]   omap = 8'hE4;
    logic [N_OUT-1:0]     esc;
    logic [2:0]           st;
    logic [ACC_W-1:0]     acc;
    logic [CNT_W-1:0]     cnt;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    esc_class_ctrl #(.ACC_W(ACC_W), .CNT_W(CNT_W), .N_SRC(N_SRC), .N_OUT(N_OUT)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .alert_hit_i(hit), .irq_pend_i(pend),
        .clr_i(clr), .cls_en_i(en), .lock_i(lock), .clr_en_i(clr_en),
        .acc_thresh_i(thresh), .tmo_cyc_i(tmo), .phase_cyc_i(ph),
        .out_en_i(oen), .out_map_i(omap), .esc_o(esc), .state_o(st),
        .acc_o(acc), .cnt_o(cnt)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_hit(input logic [N_SRC-1:0] m);
        hit = m; step(1); hit = '0;
    endtask

    task automatic pulse_clr();
        clr = 1'b1; step(1); clr = 1'b0;
    endtask

    task automatic run_len(input logic [2:0] s, output int n);
        n = 0;
        while (st == s && n < 5000) begin n++; step(1); end
    endtask

    task automatic set_phases(input int a, input int b, input int c, input int d);
        ph = {CNT_W'(d), CNT_W'(c), CNT_W'(b), CNT_W'(a)};
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
        chk("R3", "reset state", st, 0);
        chk("R3", "reset acc", acc, 0);
        chk("R3", "reset cnt", cnt, 0);
        chk("R3", "reset lines", esc, 0);
    endtask

    task automatic t_accum_escalate();
        int n;
        en = 1; thresh = 3; set_phases(2, 0, 1, 3); oen = '1; omap = 8'hE4; clr_en = 0;
        pulse_hit(3'b001); chk("R1", "acc after one hit", acc, 1);
        pulse_hit(3'b011); chk("R1", "two sources count once", acc, 2);
        pulse_hit(3'b100); chk("R1", "acc three", acc, 3);
        chk("R2", "no escalation at threshold count", st, 0);
        pulse_hit(3'b001);
        chk("R2", "phase0 after threshold hit", st, 2);
        chk("R6", "phase0 counter start", cnt, 0);
        chk("R7", "line0 in phase0", esc, 4'b0001);
        run_len(3'd2, n); chk("R6", "phase0 length", n, 3);
        chk("R7", "line1 in phase1", esc, 4'b0010);
        run_len(3'd3, n); chk("R6", "phase1 length", n, 1);
        chk("R7", "line2 in phase2", esc, 4'b0100);
        run_len(3'd4, n); chk("R6", "phase2 length", n, 2);
        chk("R7", "line3 in phase3", esc, 4'b1000);
        run_len(3'd5, n); chk("R6", "phase3 length", n, 4);
        chk("R6", "terminal reached", st, 6);
        chk("R6", "terminal counter", cnt, 0);
        pulse_hit(3'b111); step(4);
        chk("R8", "terminal held", st, 6);
        pulse_clr();
        chk("R9", "clear without permission state", st, 6);
        chk("R9", "clear without permission acc", acc, 5);
        clr_en = 1; pulse_clr();
        chk("R9", "permitted clear state", st, 0);
        chk("R9", "permitted clear acc", acc, 0);
    endtask

    task automatic t_zero_thresh_remap();
        thresh = 0; set_phases(0, 0, 0, 0); oen = 4'b0011;
        omap = {2'd2, 2'd1, 2'd0, 2'd3};
        pulse_hit(3'b010);
        chk("R2", "threshold 0 escalates on first hit", st, 2);
        chk("R7", "remapped line1 in phase0", esc, 4'b0010);
        step(1); chk("R7", "disabled line quiet in phase1", esc, 4'b0000);
        step(1); chk("R7", "disabled line quiet in phase2", esc, 4'b0000);
        step(1); chk("R7", "remapped line0 in phase3", esc, 4'b0001);
        step(1); chk("R6", "zero lengths reach terminal", st, 6);
        pulse_clr(); oen = '1; omap = 8'hE4;
    endtask

    task automatic t_timeout();
        int n;
        thresh = 100; tmo = 5; set_phases(10, 10, 10, 10);
        pend = 1; step(1);
        chk("R4", "timeout entered", st, 1);
        chk("R4", "timeout counter start", cnt, 1);
        step(2); chk("R4", "timeout counter rises", cnt, 3);
        run_len(3'd1, n); chk("R4", "timeout duration", n, 3);
        chk("R4", "timeout expiry enters phase0", st, 2);
        pend = 0; pulse_clr();
        chk("R9", "clear after timeout escalation", st, 0);
    endtask

    task automatic t_timeout_abort();
        tmo = 10; pend = 1; step(3);
        chk("R4", "counting in timeout", cnt, 3);
        pend = 0; step(1);
        chk("R5", "pending drop returns idle", st, 0);
        chk("R5", "pending drop zeroes counter", cnt, 0);
        tmo = 0; pend = 1; step(4);
        chk("R4", "zero timeout stays idle", st, 0);
        pend = 0;
    endtask

    task automatic t_precedence();
        thresh = 0; tmo = 50; pend = 1; step(3);
        chk("R4", "timeout before trigger", st, 1);
        pulse_hit(3'b001);
        chk("R6", "trigger preempts timeout", st, 2);
        pend = 0; pulse_clr();
    endtask

    task automatic t_disabled();
        en = 0; thresh = 0;
        pulse_hit(3'b001);
        chk("R11", "disabled class stays idle on hit", st, 0);
        chk("R11", "disabled class still counts", acc, 1);
        tmo = 3; pend = 1; step(5);
        chk("R11", "disabled class ignores pending", st, 0);
        pend = 0;
        hit = 3'b101; step(65540); hit = '0;
        chk("R1", "accumulator saturates", acc, 65535);
        pulse_clr();
        chk("R9", "clear from saturation", acc, 0);
        en = 1;
    endtask

    task automatic t_lock();
        lock = 1; clr_en = 1; thresh = 0; set_phases(100, 100, 100, 100);
        pulse_hit(3'b001);
        chk("R10", "locked escalation started", st, 2);
        pulse_clr();
        chk("R10", "locked clear ignored state", st, 2);
        chk("R10", "locked clear ignored acc", acc, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_accum_escalate();
                t_zero_thresh_remap();
                t_timeout();
                t_timeout_abort();
                t_precedence();
                t_disabled();
                t_lock();
            end
            begin
                repeat (190000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual expired expected done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule